// File: doc/BRIEF.md
# Fast-Charge Voltage Peak and Temperature Slope Terminator

This block watches a stream of ADC conversions from a battery charger during fast charge and decides when fast charge has to end. Each conversion is tagged as either a cell-voltage reading or a temperature-sense reading. The block averages a burst of conversions of each kind into a single sample, which rejects mains ripple. It accepts at most one sample per channel in every sample period. The length of the period is a count of `tick` pulses, so the slow real-time rate of one sample per several tens of seconds can be shortened for test.

On the voltage channel, the block keeps the highest sample seen since fast charge began. It raises `v_term` when a later sample has dropped below that peak by a configured amount. There are two detection modes. The small-drop mode averages 32 conversions per sample. The larger-drop mode averages 16 conversions per sample.

On the temperature channel, the sense voltage falls as the cell heats. The block compares each sample with the sample taken two periods before it and raises `t_term` on a large enough fall. The external comparators report whether each reading lies inside its valid window. A hold-off of a selectable number of periods at the start of fast charge suppresses the larger-drop test and the slope test. The cycle controller pulses `phase_start` when each fast-charge phase begins.

Top module: `chg_term_detect`

## Requirements
- R1: After reset, `v_term` and `t_term` are both low.
- R2: `vmode` selects the voltage test: 2'b00 and 2'b11 disable it, and `v_term` then never rises; 2'b01 selects negative-delta detection; 2'b10 selects peak-drop detection.
- R3: In peak-drop mode (`vmode`=2'b10), a voltage sample is the truncated mean of 32 accepted conversions. `v_term` rises when a sample is at least VTHR_PK (default 6) LSB below the highest earlier sample. A drop of VTHR_PK-1 does not trip it.
- R4: In negative-delta mode (`vmode`=2'b01), a voltage sample is the truncated mean of 16 accepted conversions. `v_term` rises when a sample is at least VTHR_ND (default 12) LSB below the highest earlier sample. A drop of VTHR_ND-1 does not trip it.
- R5: A voltage sample taken while `v_in_win` is low is neither tested nor allowed to raise the stored peak.
- R6: A temperature sample is the truncated mean of 16 conversions. `t_term` rises when a sample is at least TTHR (default 16) LSB below the sample taken two periods earlier, and only if `t_in_win` is high for that sample.
- R7: For the first HOLD_BASE<<`hold_sel` periods after `phase_start` (default 2, 4, 8 or 16 periods), the negative-delta test and the slope test are suppressed. The peak-drop test is not suppressed. The stored peak and the temperature history keep updating during hold-off.
- R8: `meas_chan` 0 tags voltage and 1 tags temperature. Per channel, only the first complete burst in each period forms a sample. Later conversions in the same period are ignored.
- R9: `phase_start` clears both flags, the peak, the temperature history and the hold-off count. It also restarts the period, so the next period boundary follows PERIOD_TICKS ticks later.
- R10: Once raised, a flag stays high until the next `phase_start`.
- R11: A flag rises on the clock edge that follows the edge capturing the final conversion of the deciding burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse; PERIOD_TICKS of them make one sample period |
| phase_start | input | 1 | Start of a fast-charge phase; clears state |
| meas_vld | input | 1 | An ADC conversion is present |
| meas_chan | input | 1 | 0 = cell voltage, 1 = temperature sense |
| meas_data | input | ADC_W | Conversion result in LSBs |
| vmode | input | 2 | Voltage test select (see R2) |
| hold_sel | input | 2 | Hold-off length select |
| v_in_win | input | 1 | Cell voltage inside its valid window |
| t_in_win | input | 1 | Temperature inside its valid window |
| v_term | output | 1 | Voltage-drop termination flag |
| t_term | output | 1 | Temperature-slope termination flag |

## Verification
A flag is due one clock edge after the edge that takes in the last conversion of a burst. It is then held until the next `phase_start`. The bench therefore checks both flags a quarter clock after the final edge of each sample period. In one directed peak-drop case, it also checks the flag at the negative edges immediately before and after the deciding edge. A cleared state is checked a quarter clock after the `phase_start` edge. The hold-off window is counted in whole periods, aligned to that same edge.

// File: rtl/chg_term_pkg.sv
package chg_term_pkg;

  typedef enum logic [1:0] {
    VM_OFF  = 2'b00,
    VM_NDV  = 2'b01,
    VM_PEAK = 2'b10,
    VM_OFF2 = 2'b11
  } vmode_e;

  localparam int unsigned LG_PEAK = 5;
  localparam int unsigned LG_NDV  = 4;
  localparam int unsigned LG_TEMP = 4;

  function automatic logic [2:0] volt_lg(input logic [1:0] m);
    return (m == VM_PEAK) ? 3'(LG_PEAK) : 3'(LG_NDV);
  endfunction

endpackage

// File: rtl/chg_period_timer.sv
module chg_period_timer #(
  parameter int unsigned PERIOD_TICKS = 34,
  parameter int unsigned HOLD_BASE    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] hold_sel,
  output logic       period_end,
  output logic       hold_act
);
  localparam int unsigned TW   = (PERIOD_TICKS > 1) ? $clog2(PERIOD_TICKS) : 1;
  localparam int unsigned HMAX = HOLD_BASE * 8;
  localparam int unsigned HW   = $clog2(HMAX + 1);

  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [HW-1:0] hcnt_q, hcnt_d;
  logic [HW-1:0] hlim;

  assign period_end = tick && (tcnt_q == TW'(PERIOD_TICKS - 1));
  assign hlim       = HW'(HOLD_BASE) << hold_sel;
  assign hold_act   = (hcnt_q < hlim);

  always_comb begin
    tcnt_d = tcnt_q;
    hcnt_d = hcnt_q;
    if (restart) begin
      tcnt_d = '0;
      hcnt_d = '0;
    end else if (tick) begin
      if (period_end) begin
        tcnt_d = '0;
        if (hcnt_q != HW'(HMAX)) hcnt_d = hcnt_q + 1'b1;
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      hcnt_q <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      hcnt_q <= hcnt_d;
    end
  end
endmodule

// File: rtl/chg_burst_avg.sv
module chg_burst_avg #(
  parameter int unsigned DW    = 12,
  parameter int unsigned MAXLG = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [2:0]    lg,
  input  logic [DW-1:0] din,
  output logic          s_vld,
  output logic [DW-1:0] s_val
);
  localparam int unsigned AW = DW + MAXLG;
  localparam int unsigned CW = MAXLG + 1;

  logic [AW-1:0] acc_q, acc_d, acc_sum, acc_sh;
  logic [CW-1:0] cnt_q, cnt_d, cnt_last;
  logic          done_q, done_d;
  logic          vld_d;
  logic [DW-1:0] val_q, val_d;

  assign acc_sum  = acc_q + AW'(din);
  assign acc_sh   = acc_sum >> lg;
  assign cnt_last = (CW'(1) << lg) - 1'b1;

  always_comb begin
    acc_d  = acc_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    vld_d  = 1'b0;
    val_d  = val_q;
    if (clr) begin
      acc_d  = '0;
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (en && !done_q) begin
      if (cnt_q == cnt_last) begin
        acc_d  = '0;
        cnt_d  = '0;
        done_d = 1'b1;
        vld_d  = 1'b1;
        val_d  = acc_sh[DW-1:0];
      end else begin
        acc_d = acc_sum;
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      s_vld  <= 1'b0;
      val_q  <= '0;
    end else begin
      acc_q  <= acc_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      s_vld  <= vld_d;
      val_q  <= val_d;
    end
  end

  assign s_val = val_q;
endmodule

// File: rtl/chg_volt_drop.sv
module chg_volt_drop
  import chg_term_pkg::*;
#(
  parameter int unsigned DW      = 12,
  parameter int unsigned THR_PK  = 6,
  parameter int unsigned THR_NDV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          s_vld,
  input  logic [DW-1:0] s_val,
  input  logic          in_win,
  input  logic [1:0]    mode,
  input  logic          hold_act,
  output logic          term
);
  logic [DW-1:0] peak_q, peak_d;
  logic          pkv_q, pkv_d;
  logic          term_q, term_d;
  logic [DW:0]   s_plus;
  logic          armed;

  assign s_plus = {1'b0, s_val} + ((mode == VM_NDV) ? (DW+1)'(THR_NDV) : (DW+1)'(THR_PK));
  assign armed  = (mode == VM_PEAK) || ((mode == VM_NDV) && !hold_act);

  always_comb begin
    peak_d = peak_q;
    pkv_d  = pkv_q;
    term_d = term_q;
    if (clr) begin
      peak_d = '0;
      pkv_d  = 1'b0;
      term_d = 1'b0;
    end else if (s_vld && in_win) begin
      if (armed && pkv_q && (s_plus <= {1'b0, peak_q})) term_d = 1'b1;
      if (!pkv_q || (s_val > peak_q)) begin
        peak_d = s_val;
        pkv_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      peak_q <= '0;
      pkv_q  <= 1'b0;
      term_q <= 1'b0;
    end else begin
      peak_q <= peak_d;
      pkv_q  <= pkv_d;
      term_q <= term_d;
    end
  end

  assign term = term_q;
endmodule

// File: rtl/chg_temp_slope.sv
module chg_temp_slope #(
  parameter int unsigned DW   = 12,
  parameter int unsigned TTHR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          s_vld,
  input  logic [DW-1:0] s_val,
  input  logic          in_win,
  input  logic          hold_act,
  output logic          term
);
  logic [DW-1:0] h1_q, h1_d, h2_q, h2_d;
  logic [1:0]    hc_q, hc_d;
  logic          term_q, term_d;
  logic [DW:0]   s_plus;

  assign s_plus = {1'b0, s_val} + (DW+1)'(TTHR);

  always_comb begin
    h1_d   = h1_q;
    h2_d   = h2_q;
    hc_d   = hc_q;
    term_d = term_q;
    if (clr) begin
      h1_d   = '0;
      h2_d   = '0;
      hc_d   = '0;
      term_d = 1'b0;
    end else if (s_vld) begin
      if (in_win && !hold_act && (hc_q == 2'd2) && ({1'b0, h2_q} >= s_plus))
        term_d = 1'b1;
      h2_d = h1_q;
      h1_d = s_val;
      if (hc_q != 2'd2) hc_d = hc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h1_q   <= '0;
      h2_q   <= '0;
      hc_q   <= '0;
      term_q <= 1'b0;
    end else begin
      h1_q   <= h1_d;
      h2_q   <= h2_d;
      hc_q   <= hc_d;
      term_q <= term_d;
    end
  end

  assign term = term_q;
endmodule

// File: rtl/chg_term_detect.sv
module chg_term_detect
  import chg_term_pkg::*;
#(
  parameter int unsigned ADC_W        = 12,
  parameter int unsigned PERIOD_TICKS = 34,
  parameter int unsigned HOLD_BASE    = 2,
  parameter int unsigned VTHR_PK      = 6,
  parameter int unsigned VTHR_ND      = 12,
  parameter int unsigned TTHR         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             phase_start,
  input  logic             meas_vld,
  input  logic             meas_chan,
  input  logic [ADC_W-1:0] meas_data,
  input  logic [1:0]       vmode,
  input  logic [1:0]       hold_sel,
  input  logic             v_in_win,
  input  logic             t_in_win,
  output logic             v_term,
  output logic             t_term
);
  localparam int unsigned NCH = 2;

  logic             rs_q1, rs_q2, rst_s_n;
  logic             period_end, hold_act, burst_clr;
  logic [NCH-1:0]   smp_vld;
  logic [ADC_W-1:0] smp_val [NCH];
  logic [2:0]       ch_lg   [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s_n = rs_q2;

  chg_period_timer #(.PERIOD_TICKS(PERIOD_TICKS), .HOLD_BASE(HOLD_BASE)) u_timer (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .restart(phase_start),
    .hold_sel(hold_sel), .period_end(period_end), .hold_act(hold_act)
  );

  assign burst_clr = phase_start || period_end;
  assign ch_lg[0]  = volt_lg(vmode);
  assign ch_lg[1]  = 3'(LG_TEMP);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chg_burst_avg #(.DW(ADC_W), .MAXLG(LG_PEAK)) u_avg (
      .clk(clk), .rst_n(rst_s_n), .clr(burst_clr),
      .en(meas_vld && (meas_chan == 1'(c))),
      .lg(ch_lg[c]), .din(meas_data),
      .s_vld(smp_vld[c]), .s_val(smp_val[c])
    );
  end

  chg_volt_drop #(.DW(ADC_W), .THR_PK(VTHR_PK), .THR_NDV(VTHR_ND)) u_vdrop (
    .clk(clk), .rst_n(rst_s_n), .clr(phase_start),
    .s_vld(smp_vld[0]), .s_val(smp_val[0]), .in_win(v_in_win),
    .mode(vmode), .hold_act(hold_act), .term(v_term)
  );

  chg_temp_slope #(.DW(ADC_W), .TTHR(TTHR)) u_tslope (
    .clk(clk), .rst_n(rst_s_n), .clr(phase_start),
    .s_vld(smp_vld[1]), .s_val(smp_val[1]), .in_win(t_in_win),
    .hold_act(hold_act), .term(t_term)
  );
endmodule

// File: rtl/chg_term_chk.sv
module chg_term_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase_start,
  input logic [1:0] vmode,
  input logic       hold_act,
  input logic       v_term,
  input logic       t_term
);
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    phase_start |=> (!v_term && !t_term)); // R9
  AST_V_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (v_term && !phase_start) |=> v_term); // R10
  AST_T_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (t_term && !phase_start) |=> t_term); // R10
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_term && !phase_start && ((vmode == 2'b00) || (vmode == 2'b11))) |=> !v_term); // R2
  AST_SLOPE_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!t_term && hold_act) |=> !t_term); // R7
  AST_NDV_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!v_term && hold_act && (vmode == 2'b01)) |=> !v_term); // R7
endmodule

bind chg_term_detect chg_term_chk u_chk (
  .clk(clk), .rst_n(rst_s_n), .phase_start(phase_start), .vmode(vmode),
  .hold_act(hold_act), .v_term(v_term), .t_term(t_term)
);

// File: tb/tb_chg_term_detect.sv
module tb_chg_term_detect;
  localparam int CLK_PER = 10;
  localparam int P       = 64;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, phase_start = 1'b0;
  logic meas_vld = 1'b0, meas_chan = 1'b0;
  logic [11:0] meas_data = '0;
  logic [1:0] vmode = 2'b00, hold_sel = 2'b00;
  logic v_in_win = 1'b1, t_in_win = 1'b1;
  logic v_term, t_term;

  int checks = 0, errors = 0, pcyc = 0;
  int m_pk, m_pkv, m_h1, m_h2, m_hc, m_vt, m_tt, m_per;

  always #(CLK_PER/2) clk = ~clk;

  chg_term_detect #(.PERIOD_TICKS(P)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase_start(phase_start),
    .meas_vld(meas_vld), .meas_chan(meas_chan), .meas_data(meas_data),
    .vmode(vmode), .hold_sel(hold_sel), .v_in_win(v_in_win), .t_in_win(t_in_win),
    .v_term(v_term), .t_term(t_term)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic int hold_len(input int sel);
    return 2 << sel;
  endfunction

  function automatic string vtag();
    return (vmode == 2'b10) ? "R3" : (vmode == 2'b01) ? "R4" : "R2";
  endfunction

  task automatic step(input logic mv, input logic ch, input int d, input int ck);
    @(negedge clk);
    if (ck == 1) chk(v_term, 1'b0, "R11 before deciding edge");
    if (ck == 2) chk(v_term, 1'b1, "R11 after deciding edge");
    phase_start = 1'b0;
    meas_vld = mv; meas_chan = ch; meas_data = d[11:0];
    @(posedge clk);
    pcyc++;
  endtask

  task automatic start_phase(input logic [1:0] m, input logic [1:0] s);
    @(negedge clk);
    vmode = m; hold_sel = s; phase_start = 1'b1; meas_vld = 1'b0;
    @(posedge clk);
    pcyc = 0;
    m_pk = 0; m_pkv = 0; m_h1 = 0; m_h2 = 0; m_hc = 0; m_vt = 0; m_tt = 0; m_per = 0;
    #(CLK_PER/4);
    chk(v_term, 1'b0, "R9 v_term cleared");
    chk(t_term, 1'b0, "R9 t_term cleared");
  endtask

  task automatic model_v(input int s, input logic w);
    int thr;
    logic hold, arm;
    if (!w) return;
    thr  = (vmode == 2'b01) ? 12 : 6;
    hold = (m_per < hold_len(hold_sel));
    arm  = (vmode == 2'b10) || (vmode == 2'b01 && !hold);
    if (arm && m_pkv && (m_pk - s >= thr)) m_vt = 1;
    if (!m_pkv || s > m_pk) begin m_pk = s; m_pkv = 1; end
  endtask

  task automatic model_t(input int s, input logic w);
    if (w && (m_per >= hold_len(hold_sel)) && m_hc == 2 && (m_h2 - s >= 16)) m_tt = 1;
    m_h2 = m_h1; m_h1 = s;
    if (m_hc < 2) m_hc++;
  endtask

  // one sample period: nva of va, nvb of vb, 16 temp conversions of tv, idle to the boundary
  task automatic run_per(input int va, input int nva, input int vb, input int nvb,
                         input int tv, input logic vw, input logic tw, input logic tchk);
    int n, ca, cb;
    v_in_win = vw; t_in_win = tw;
    n  = (vmode == 2'b10) ? 32 : 16;
    ca = (nva < n) ? nva : n;
    cb = (nvb < n - ca) ? nvb : n - ca;
    for (int i = 0; i < nva; i++) step(1'b1, 1'b0, va, 0);
    for (int i = 0; i < nvb; i++) step(1'b1, 1'b0, vb, 0);
    for (int i = 0; i < 16; i++)
      step(1'b1, 1'b1, tv, (tchk && i == 0) ? 1 : (tchk && i == 1) ? 2 : 0);
    while (pcyc < P) step(1'b0, 1'b0, 0, 0);
    pcyc = 0;
    if (ca + cb == n) model_v((ca * va + cb * vb) / n, vw);
    model_t(tv, tw);
    m_per++;
    #(CLK_PER/4);
    chk(v_term, m_vt[0], {vtag(), " v_term vs model"});
    chk(t_term, m_tt[0], "R6 t_term vs model");
  endtask

  initial begin
    #(CLK_PER * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vl, tl, nv;
    logic [1:0] rm;
    void'($urandom(32'h1234abcd));
    repeat (3) @(posedge clk);
    #(CLK_PER/4);
    chk(v_term, 1'b0, "R1 v_term reset");
    chk(t_term, 1'b0, "R1 t_term reset");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R3/R7: peak-drop trips during hold-off; split 32-burst averages to 994; R11 timing
    start_phase(2'b10, 2'b00);
    run_per(1000, 32, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R3 first sample");
    run_per(1000, 16, 988, 16, 2000, 1, 1, 1);
    chk(v_term, 1'b1, "R3 avg of 32 drop 6 in hold-off R7");
    run_per(1100, 32, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b1, "R10 flag held");

    // R3 boundary: drop of 5 does not trip
    start_phase(2'b10, 2'b00);
    run_per(1000, 32, 0, 0, 2000, 1, 1, 0);
    run_per(995, 32, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R3 drop 5 no trip");
    run_per(994, 32, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b1, "R3 drop 6 trips");

    // R4/R7/R8: negative-delta hold-off, boundary, extra conversions ignored
    start_phase(2'b01, 2'b00);
    run_per(1000, 16, 0, 0, 2000, 1, 1, 0);
    run_per(980, 16, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R7 ndv suppressed in hold-off");
    run_per(989, 16, 900, 16, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R8 extra burst ignored, R4 drop 11");
    run_per(988, 16, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b1, "R4 drop 12 trips");

    // R2: disabled encodings
    start_phase(2'b00, 2'b00);
    run_per(1000, 16, 0, 0, 2000, 1, 1, 0);
    for (int k = 0; k < 3; k++) run_per(900, 16, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R2 mode 00 silent");
    start_phase(2'b11, 2'b00);
    run_per(1000, 16, 0, 0, 2000, 1, 1, 0);
    for (int k = 0; k < 3; k++) run_per(900, 16, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R2 mode 11 silent");

    // R5: out-of-window samples neither test nor raise the peak
    start_phase(2'b10, 2'b00);
    run_per(1000, 32, 0, 0, 2000, 1, 1, 0);
    run_per(900, 32, 0, 0, 2000, 0, 1, 0);
    chk(v_term, 1'b0, "R5 low sample out of window");
    run_per(1100, 32, 0, 0, 2000, 0, 1, 0);
    run_per(1094, 32, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R5 peak not raised out of window");

    // R6/R7: slope test with 4-period hold-off
    start_phase(2'b00, 2'b01);
    run_per(1000, 16, 0, 0, 2000, 1, 1, 0);
    run_per(1000, 16, 0, 0, 1970, 1, 1, 0);
    run_per(1000, 16, 0, 0, 1940, 1, 1, 0);
    run_per(1000, 16, 0, 0, 1910, 1, 1, 0);
    chk(t_term, 1'b0, "R7 slope held off 4 periods");
    run_per(1000, 16, 0, 0, 1880, 1, 0, 0);
    chk(t_term, 1'b0, "R6 out of window");
    run_per(1000, 16, 0, 0, 1895, 1, 1, 0);
    chk(t_term, 1'b0, "R6 drop 15 no trip");
    run_per(1000, 16, 0, 0, 1864, 1, 1, 0);
    chk(t_term, 1'b1, "R6 drop 16 trips");

    // R9: clear after trip, old peak forgotten
    start_phase(2'b10, 2'b00);
    run_per(990, 32, 0, 0, 2000, 1, 1, 0);
    chk(v_term, 1'b0, "R9 peak cleared");

    // random phases against the model
    for (int ph = 0; ph < 4; ph++) begin
      rm = 2'($urandom_range(0, 3));
      start_phase(rm, 2'($urandom_range(0, 1)));
      vl = 2000; tl = 2500;
      nv = (rm == 2'b10) ? 32 : 16;
      for (int k = 0; k < 10; k++) begin
        vl += $urandom_range(0, 16) - 9;
        tl -= $urandom_range(0, 14);
        run_per(vl, nv, 0, 0, tl, ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0), 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule